// File: doc/BRIEF.md
# Four-Channel LED Blink Controller

This block drives four indicator LEDs from a small set of configuration registers. A host writes the registers over a Wishbone classic slave port and can read them back. For each LED the registers select off, steady on or blinking. A blinking LED also has its own half-period, counted in timer ticks.

A prescaler divides the system clock into a slow timer tick. Its rate is set by two parameters, the clock frequency (nominally 100 MHz) and the tick frequency. Each LED has its own lane: a tick counter and a phase bit that toggles each time the counter reaches that LED's half-period. A polarity parameter selects whether the output pins are active-high or active-low.

Register map (8-bit data, 3-bit word address):

- Address 0 is the mode register. Bits 3:0 are the lit enables for LEDs 3..0. Bits 7:4 are the blink enables for LEDs 3..0.
- Addresses 1, 2, 3 and 4 hold the half-periods of LEDs 0, 1, 2 and 3.
- Addresses 5 to 7 are unmapped.

Top module: `led_blink_ctrl`

## Requirements
- R1: After reset every register reads 0 and all four pins sit at their inactive level.
- R2: A LED whose lit enable (address 0, bit n for LED n) is 0 stays dark, whatever its blink enable (address 0, bit 4+n) and half-period are.
- R3: A LED with its lit enable at 1 and its blink enable at 0 is steadily lit.
- R4: A LED with both enables at 1 and a half-period N greater than 0 alternates between lit and dark. Successive output changes are N ticks apart.
- R5: A LED with both enables at 1 and a half-period of 0 is steadily lit.
- R6: The timer tick occurs once every CLK_HZ/TICK_HZ clock cycles. A blinking LED therefore changes level every N*CLK_HZ/TICK_HZ cycles.
- R7: With ACTIVE_LOW=0 a lit LED drives its pin to 1. With ACTIVE_LOW=1 all four pins are inverted.
- R8: The acknowledge rises in the cycle after cyc and stb are both seen high, and lasts exactly one cycle.
- R9: A read returns the value last written. Address 0 returns the mode byte and addresses 1 to 4 return the half-periods of LEDs 0 to 3.
- R10: Reads of addresses 5 to 7 return 0, and writes to those addresses change no register.
- R11: Pin levels change only one cycle after a timer tick or a register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| wb_cyc_i | input | 1 | Wishbone bus cycle |
| wb_stb_i | input | 1 | Wishbone strobe |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | 3 | Register word address |
| wb_dat_i | input | 8 | Write data |
| wb_dat_o | output | 8 | Read data, valid with the acknowledge |
| wb_ack_o | output | 1 | Single-cycle acknowledge |
| led_o | output | 4 | LED pins, polarity set by ACTIVE_LOW |

## Verification
The acknowledge properties assume a master that holds cyc and stb for exactly one cycle beyond the request. The master drops the strobe once it sees the acknowledge and starts no new request in that same cycle. The bench's bus tasks follow this pattern: each raises the strobe on a falling edge, waits one cycle and then lowers it.

The checks on when pins may change assume that reset is driven synchronously and held for whole cycles. The bench applies reset only on falling edges.

Blink intervals are measured only between two successive pin changes. The first change after a mode write depends on where the free-running prescaler happens to be, so it is not timed.

// File: rtl/led_blink_pkg.sv
package led_blink_pkg;
    localparam int LED_N  = 4;
    localparam int DATA_W = 8;
    localparam int ADR_W  = 3;

    typedef struct packed {
        logic [LED_N-1:0]             lit_en;
        logic [LED_N-1:0]             blink_en;
        logic [LED_N-1:0][DATA_W-1:0] half;
    } led_cfg_t;
endpackage

// File: rtl/led_tick_gen.sv
module led_tick_gen #(
    parameter int DIV = 100000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tick_st_t;

    tick_st_t st_d, st_q;
    logic     wrap;

    always_comb begin
        st_d = st_q;
        wrap = (st_q.cnt == CW'(DIV - 1));
        if (wrap) st_d.cnt = '0;
        else      st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign tick = wrap;
endmodule

// File: rtl/led_wb_regs.sv
module led_wb_regs
    import led_blink_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc,
    input  logic              stb,
    input  logic              we,
    input  logic [ADR_W-1:0]  adr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              ack,
    output led_cfg_t          cfg
);
    typedef struct packed {
        led_cfg_t          cfg;
        logic              ack;
        logic [DATA_W-1:0] rdata;
    } regs_st_t;

    regs_st_t st_d, st_q;
    logic     req;

    always_comb begin
        st_d       = st_q;
        st_d.ack   = 1'b0;
        req        = cyc && stb && !st_q.ack;
        if (req) begin
            st_d.ack   = 1'b1;
            st_d.rdata = '0;
            if (adr == '0)
                st_d.rdata = {st_q.cfg.blink_en, st_q.cfg.lit_en};
            for (int i = 0; i < LED_N; i++) begin
                if (adr == ADR_W'(i + 1)) st_d.rdata = st_q.cfg.half[i];
            end
            if (we) begin
                if (adr == '0) begin
                    st_d.cfg.lit_en   = wdata[LED_N-1:0];
                    st_d.cfg.blink_en = wdata[2*LED_N-1:LED_N];
                end
                for (int i = 0; i < LED_N; i++) begin
                    if (adr == ADR_W'(i + 1)) st_d.cfg.half[i] = wdata;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign rdata = st_q.rdata;
    assign ack   = st_q.ack;
    assign cfg   = st_q.cfg;
endmodule

// File: rtl/led_blink_lane.sv
module led_blink_lane
    import led_blink_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              lit_en,
    input  logic              blink_en,
    input  logic [DATA_W-1:0] half,
    output logic              lit
);
    typedef struct packed {
        logic [DATA_W-1:0] cnt;
        logic              phase;
    } lane_st_t;

    lane_st_t st_d, st_q;
    logic     blinking;

    always_comb begin
        st_d     = st_q;
        blinking = lit_en && blink_en && (half != '0);
        if (!blinking) begin
            st_d.cnt   = '0;
            st_d.phase = 1'b1;
        end else if (tick) begin
            if (st_q.cnt >= half - 1'b1) begin
                st_d.cnt   = '0;
                st_d.phase = !st_q.phase;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{cnt: '0, phase: 1'b1};
        else     st_q <= st_d;
    end

    assign lit = lit_en && (blinking ? st_q.phase : 1'b1);
endmodule

// File: rtl/led_blink_ctrl.sv
module led_blink_ctrl
    import led_blink_pkg::*;
#(
    parameter int CLK_HZ     = 100_000_000,
    parameter int TICK_HZ    = 1000,
    parameter bit ACTIVE_LOW = 1'b0
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wb_cyc_i,
    input  logic              wb_stb_i,
    input  logic              wb_we_i,
    input  logic [ADR_W-1:0]  wb_adr_i,
    input  logic [DATA_W-1:0] wb_dat_i,
    output logic [DATA_W-1:0] wb_dat_o,
    output logic              wb_ack_o,
    output logic [LED_N-1:0]  led_o
);
    localparam int TICK_DIV = (CLK_HZ / TICK_HZ > 0) ? CLK_HZ / TICK_HZ : 1;

    logic             tick;
    led_cfg_t         cfg;
    logic [LED_N-1:0] lit;

    led_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk  (clk_i),
        .rst  (rst_i),
        .tick (tick)
    );

    led_wb_regs u_regs (
        .clk   (clk_i),
        .rst   (rst_i),
        .cyc   (wb_cyc_i),
        .stb   (wb_stb_i),
        .we    (wb_we_i),
        .adr   (wb_adr_i),
        .wdata (wb_dat_i),
        .rdata (wb_dat_o),
        .ack   (wb_ack_o),
        .cfg   (cfg)
    );

    for (genvar g = 0; g < LED_N; g++) begin : g_lane
        led_blink_lane u_lane (
            .clk      (clk_i),
            .rst      (rst_i),
            .tick     (tick),
            .lit_en   (cfg.lit_en[g]),
            .blink_en (cfg.blink_en[g]),
            .half     (cfg.half[g]),
            .lit      (lit[g])
        );
        assign led_o[g] = lit[g] ^ ACTIVE_LOW;
    end
endmodule

// File: rtl/led_blink_chk.sv
module led_blink_chk #(
    parameter int DIV        = 4,
    parameter bit ACTIVE_LOW = 1'b0
) (
    input logic       clk,
    input logic       rst,
    input logic       cyc,
    input logic       stb,
    input logic       we,
    input logic       ack,
    input logic       tick,
    input logic [3:0] led
);
    logic [31:0] gap;
    logic        wr;

    assign wr = cyc && stb && we && !ack;

    always_ff @(posedge clk) begin
        if (rst || tick) gap <= '0;
        else             gap <= gap + 1;
    end

    // R8
    ack_single_chk: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

    // R8
    ack_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc && stb && !ack) |=> ack);

    // R8
    ack_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        ack |-> $past(cyc && stb));

    // R6
    tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        tick |-> (gap == 32'(DIV - 1)));

    // R11
    led_change_cause_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(led) |-> $past(tick || wr));

    // R1
    reset_dark_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (led == {4{ACTIVE_LOW}}));
endmodule

bind led_blink_ctrl led_blink_chk #(.DIV(TICK_DIV), .ACTIVE_LOW(ACTIVE_LOW)) u_chk (
    .clk  (clk_i),
    .rst  (rst_i),
    .cyc  (wb_cyc_i),
    .stb  (wb_stb_i),
    .we   (wb_we_i),
    .ack  (wb_ack_o),
    .tick (tick),
    .led  (led_o)
);

// File: tb/sim_led_blink_ctrl.sv
`timescale 1ns/1ps
module sim_led_blink_ctrl;
    localparam int DIV = 4;
    localparam int NV  = 7;
    // fields: mode[23:16] half[15:8] steady_lit[7:4] blinking[3:0]
    localparam logic [23:0] VEC [NV] = '{
        {8'h00, 8'd3, 4'b0000, 4'b0000},   // R2 all dark
        {8'h0F, 8'd3, 4'b1111, 4'b0000},   // R3 steady
        {8'hF0, 8'd3, 4'b0000, 4'b0000},   // R2 blink without lit
        {8'hFF, 8'd0, 4'b1111, 4'b0000},   // R5 half zero
        {8'h35, 8'd2, 4'b0100, 4'b0001},   // R2 R3 R4 mixed
        {8'hCF, 8'd3, 4'b0011, 4'b1100},   // R3 R4 mixed
        {8'hFF, 8'd1, 4'b0000, 4'b1111}    // R4 fastest
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cyc = 1'b0, stb = 1'b0, we = 1'b0;
    logic [2:0] adr = '0;
    logic [7:0] wdat = '0;
    logic [7:0] rd0, rd1;
    logic       ack0, ack1;
    logic [3:0] led0, led1;
    int         checks = 0, fails = 0;
    int         hv [4];
    bit         done = 0;

    always #2.5 clk = ~clk;

    led_blink_ctrl #(.CLK_HZ(1000), .TICK_HZ(250), .ACTIVE_LOW(1'b0)) u0 (
        .clk_i(clk), .rst_i(rst), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
        .wb_adr_i(adr), .wb_dat_i(wdat), .wb_dat_o(rd0), .wb_ack_o(ack0), .led_o(led0));

    led_blink_ctrl #(.CLK_HZ(1000), .TICK_HZ(250), .ACTIVE_LOW(1'b1)) u1 (
        .clk_i(clk), .rst_i(rst), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
        .wb_adr_i(adr), .wb_dat_i(wdat), .wb_dat_o(rd1), .wb_ack_o(ack1), .led_o(led1));

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic bus(input logic w, input logic [2:0] a, input logic [7:0] d,
                       output logic [7:0] q);
        @(negedge clk);
        cyc = 1'b1; stb = 1'b1; we = w; adr = a; wdat = d;
        @(negedge clk);
        check("R8 ack one cycle after request", int'(ack0), 1);
        q = rd0;
        cyc = 1'b0; stb = 1'b0; we = 1'b0;
        @(negedge clk);
        check("R8 ack lasts one cycle", int'(ack0), 0);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        logic [7:0] q;
        bus(1'b1, a, d, q);
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] q);
        bus(1'b0, a, 8'h00, q);
    endtask

    task automatic observe(input logic [3:0] lvl, input logic [3:0] blk, input string tag);
        int last [4];
        int nint [4];
        int bad  [4];
        int maxh = 1;
        int badlvl = 0;
        int badpol = 0;
        int win;
        logic [3:0] prev;
        for (int i = 0; i < 4; i++) begin
            last[i] = -1; nint[i] = 0; bad[i] = 0;
            if (hv[i] > maxh) maxh = hv[i];
        end
        win = 3 * maxh * DIV + 2 * DIV;
        @(negedge clk);
        prev = led0;
        for (int c = 1; c <= win; c++) begin
            @(negedge clk);
            for (int i = 0; i < 4; i++) begin
                if (led0[i] != prev[i]) begin
                    if (last[i] >= 0) begin
                        nint[i]++;
                        if (c - last[i] != hv[i] * DIV) bad[i]++;
                    end
                    last[i] = c;
                end
                if (!blk[i] && led0[i] != lvl[i]) badlvl++;
            end
            if (led1 !== ~led0) badpol++;
            prev = led0;
        end
        for (int i = 0; i < 4; i++) begin
            if (blk[i]) begin
                check({tag, " R4 R6 interval equals half*DIV"}, bad[i], 0);
                check({tag, " R4 at least two intervals"}, int'(nint[i] >= 2), 1);
            end
        end
        check({tag, " R2 R3 R5 steady levels"}, badlvl, 0);
        check({tag, " R7 active-low pins inverted"}, badpol, 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            fails++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] q;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 pins dark active-high", int'(led0), 0);
        check("R7 pins dark active-low", int'(led1), 15);
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), q);
            check("R1 register reset value", int'(q), 0);
        end

        // vector table
        for (int v = 0; v < NV; v++) begin
            for (int i = 0; i < 4; i++) begin
                hv[i] = int'(VEC[v][15:8]);
                wr(3'(i + 1), VEC[v][15:8]);
            end
            wr(3'd0, VEC[v][23:16]);
            observe(VEC[v][7:4], VEC[v][3:0], $sformatf("vec%0d", v));
        end

        // R4 R6 distinct half-periods per LED
        hv = '{1, 2, 3, 4};
        for (int i = 0; i < 4; i++) wr(3'(i + 1), 8'(hv[i]));
        wr(3'd0, 8'hFF);
        observe(4'b0000, 4'b1111, "distinct");

        // R9 readback
        rd(3'd0, q); check("R9 mode readback", int'(q), 8'hFF);
        for (int i = 0; i < 4; i++) begin
            rd(3'(i + 1), q);
            check("R9 half readback", int'(q), i + 1);
        end
        wr(3'd3, 8'hA7);
        rd(3'd3, q); check("R9 half of LED2 readback", int'(q), 8'hA7);

        // R10 unmapped addresses
        for (int a = 5; a < 8; a++) wr(3'(a), 8'hFF);
        for (int a = 5; a < 8; a++) begin
            rd(3'(a), q);
            check("R10 unmapped reads zero", int'(q), 0);
        end
        rd(3'd0, q); check("R10 mode untouched", int'(q), 8'hFF);
        rd(3'd1, q); check("R10 half0 untouched", int'(q), 1);
        rd(3'd4, q); check("R10 half3 untouched", int'(q), 4);

        // R1 reset in mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check("R1 dark after mid-run reset", int'(led0), 0);
        rd(3'd0, q); check("R1 mode cleared by reset", int'(q), 0);
        rd(3'd2, q); check("R1 half cleared by reset", int'(q), 0);

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule